// File: doc/BRIEF.md
# Bus Hold Request Arbiter

This block lets an external bus master borrow the processor's system bus. The master raises a hold request; the arbiter samples that request on rising clock edges, waits until the processor's bus-cycle sequencer reports that the current cycle has reached its final state, and only then grants the bus. At the grant it raises the acknowledge output, tells the sequencer to stop starting new cycles, and asks the processor's address, data and strobe drivers to go to high impedance.

A cycle already in progress is never cut short: a request that lands mid-cycle simply waits for the closing state. The grant stays in force for as long as the sampled request remains high. When the sampled request is seen low, the acknowledge, suspend and float outputs all drop on the next falling clock edge, half a cycle after the rising edge that saw the request go away, so the sequencer can resume on the following rising edge. The external master follows the usual rule: raise the request, wait for the acknowledge, then drive the bus.

Top module: `bus_hold_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the grant; hlda, bus_float and suspend read 0 from the first clock after reset is sampled, including when reset arrives while the bus is granted.
- R2: hold_req passes through SYNC_STAGES rising-edge sample registers; a request raised between edges can cause a grant no earlier than rising edge SYNC_STAGES+1 after it appears.
- R3: The grant happens only at a rising edge where cycle_end is 1 and the sampled request is 1; hlda becomes 1 just after that edge.
- R4: With cycle_end held at 0, a high request produces no grant however long it lasts; with the request at 0, cycle_end pulses produce no grant.
- R5: While the sampled request stays 1, hlda stays 1 on every following cycle.
- R6: After hold_req goes low, hlda stays 1 through the SYNC_STAGES rising edges that carry the low value through the sample registers, and falls at the falling edge that follows the last of them.
- R7: bus_float and suspend equal hlda at all sample points.
- R8: After a release, a new grant needs a fresh rising edge with cycle_end at 1 while the sampled request is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge samples and grants, falling edge releases |
| rst | input | 1 | Synchronous active-high reset |
| hold_req | input | 1 | Bus request from the external master |
| cycle_end | input | 1 | High during the closing state of the sequencer's current bus cycle |
| hlda | output | 1 | Bus grant acknowledge to the external master |
| bus_float | output | 1 | High-impedance enable for the processor's address, data and strobe outputs |
| suspend | output | 1 | Tells the bus-cycle sequencer to start no new cycle |

## Verification
The bench builds the arbiter with SYNC_STAGES set to 2 rather than the default 1, so the request passes through a real two-register chain. This makes the grant latency, the early-grant window and the delayed release all span more than one edge, so an off-by-one in the sample chain, a grant taken on the raw input, or a release taken on the rising instead of the falling edge each shows up as a wrong value at a specific half-cycle sample point.

// File: rtl/bha_pkg.sv
`timescale 1ns/1ps
package bha_pkg;

    typedef enum logic {
        ARB_RUN  = 1'b0,
        ARB_HELD = 1'b1
    } arb_mode_e;

    typedef struct packed {
        logic float_en;
        logic susp;
        logic ack;
    } arb_out_t;

    function automatic logic take_bus(input arb_mode_e mode,
                                      input logic      closing,
                                      input logic      req_seen);
        return (mode == ARB_RUN) && closing && req_seen;
    endfunction

    function automatic arb_out_t drive_outs(input logic granted_now);
        arb_out_t o;
        o.float_en = granted_now;
        o.susp     = granted_now;
        o.ack      = granted_now;
        return o;
    endfunction

endpackage

// File: rtl/bha_sampler.sv
`timescale 1ns/1ps
module bha_sampler #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_in,
    output logic req_seen
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= req_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], req_in};
            end
        end
    endgenerate

    assign req_seen = chain[LAST];

endmodule

// File: rtl/bha_grant.sv
`timescale 1ns/1ps
module bha_grant
    import bha_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      closing,
    input  logic      req_seen,
    input  logic      drop_pending,
    output arb_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= ARB_RUN;
        end else if (mode == ARB_HELD) begin
            if (drop_pending) mode <= ARB_RUN;
        end else if (take_bus(mode, closing, req_seen)) begin
            mode <= ARB_HELD;
        end
    end

endmodule

// File: rtl/bha_release.sv
`timescale 1ns/1ps
module bha_release
    import bha_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  arb_mode_e mode,
    input  logic      req_seen,
    output logic      drop_pending
);
    always_ff @(negedge clk) begin
        if (rst) drop_pending <= 1'b0;
        else     drop_pending <= (mode == ARB_HELD) && !req_seen;
    end

endmodule

// File: rtl/bus_hold_arbiter.sv
`timescale 1ns/1ps
module bus_hold_arbiter
    import bha_pkg::*;
#(
    parameter int SYNC_STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_req,
    input  logic cycle_end,
    output logic hlda,
    output logic bus_float,
    output logic suspend
);
    logic      hold_seen;
    logic      drop_pending;
    arb_mode_e mode;
    logic      granted;
    arb_out_t  outs;

    bha_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .req_in   (hold_req),
        .req_seen (hold_seen)
    );

    bha_grant u_grant (
        .clk          (clk),
        .rst          (rst),
        .closing      (cycle_end),
        .req_seen     (hold_seen),
        .drop_pending (drop_pending),
        .mode         (mode)
    );

    bha_release u_release (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode),
        .req_seen     (hold_seen),
        .drop_pending (drop_pending)
    );

    assign granted   = (mode == ARB_HELD) && !drop_pending;
    assign outs      = drive_outs(granted);
    assign hlda      = outs.ack;
    assign bus_float = outs.float_en;
    assign suspend   = outs.susp;

endmodule

// File: rtl/bha_checker.sv
`timescale 1ns/1ps
module bha_checker (
    input logic clk,
    input logic rst,
    input logic cycle_end,
    input logic hold_seen,
    input logic held,
    input logic hlda,
    input logic bus_float,
    input logic suspend
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!hlda && !bus_float && !suspend));

    assert_grant_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(hlda) && hlda) |-> ($past(cycle_end) && $past(hold_seen)));

    assert_hold_keeps_grant_R5: assert property (@(negedge clk) disable iff (rst)
        (hlda && hold_seen) |=> hlda);

    assert_release_on_fall_R6: assert property (@(negedge clk) disable iff (rst)
        (held && !hold_seen) |=> !hlda);

endmodule

bind bus_hold_arbiter bha_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cycle_end (cycle_end),
    .hold_seen (hold_seen),
    .held      (mode == bha_pkg::ARB_HELD),
    .hlda      (hlda),
    .bus_float (bus_float),
    .suspend   (suspend)
);

// File: tb/bus_hold_arbiter_test.sv
`timescale 1ns/1ps
module bus_hold_arbiter_test;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_req = 1'b0;
    logic cycle_end = 1'b0;
    logic hlda, bus_float, suspend;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    bus_hold_arbiter #(.SYNC_STAGES(SYNC)) uut (
        .clk       (clk),
        .rst       (rst),
        .hold_req  (hold_req),
        .cycle_end (cycle_end),
        .hlda      (hlda),
        .bus_float (bus_float),
        .suspend   (suspend)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outs(input string req, input logic exp);
        check(req, hlda, exp);
        check({req, "/R7 float"}, bus_float, exp);
        check({req, "/R7 suspend"}, suspend, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #4;
    endtask

    task automatic fall();
        @(negedge clk);
        #4;
    endtask

    task automatic test_reset();
        rst = 1'b1; hold_req = 1'b0; cycle_end = 1'b0;
        repeat (3) tick();
        check_outs("R1 in reset", 1'b0);
        rst = 1'b0;
        tick();
        check_outs("R1 after reset", 1'b0);
    endtask

    task automatic test_latency();
        hold_req = 1'b1; cycle_end = 1'b1;
        for (int i = 0; i < SYNC; i++) begin
            tick();
            check("R2 no grant before chain fills", hlda, 1'b0);
        end
        tick();
        check_outs("R3 grant at boundary", 1'b1);
        cycle_end = 1'b0;
    endtask

    task automatic test_hold_keeps();
        for (int i = 0; i < 5; i++) begin
            tick();
            check_outs("R5 grant kept", 1'b1);
        end
    endtask

    task automatic test_release();
        hold_req = 1'b0;
        for (int i = 0; i < SYNC; i++) begin
            tick();
            check("R6 still granted at rising edge", hlda, 1'b1);
        end
        fall();
        check_outs("R6 dropped at falling edge", 1'b0);
    endtask

    task automatic test_no_early();
        hold_req = 1'b1; cycle_end = 1'b0;
        for (int i = 0; i < SYNC + 4; i++) begin
            tick();
            check("R4 no grant without cycle_end", hlda, 1'b0);
        end
        cycle_end = 1'b1;
        tick();
        check_outs("R8 regrant at new boundary", 1'b1);
        cycle_end = 1'b0;
    endtask

    task automatic test_end_without_hold();
        hold_req = 1'b0; cycle_end = 1'b1;
        for (int i = 0; i < SYNC + 3; i++) begin
            tick();
            check("R4 no grant without request", hlda, 1'b0);
        end
        cycle_end = 1'b0;
    endtask

    task automatic test_reset_in_hold();
        hold_req = 1'b1; cycle_end = 1'b1;
        repeat (SYNC + 1) tick();
        check("R3 grant before reset", hlda, 1'b1);
        cycle_end = 1'b0;
        rst = 1'b1;
        tick();
        check_outs("R1 reset during grant", 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R8 no grant without boundary after reset", hlda, 1'b0);
        end
        cycle_end = 1'b1;
        tick();
        check("R8 grant at boundary after reset", hlda, 1'b1);
        cycle_end = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_latency();
        test_hold_keeps();
        test_release();
        test_no_early();
        test_release();
        test_end_without_hold();
        test_reset_in_hold();
        test_release();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule